// File: doc/BRIEF.md
# Shared-Bus Memory Bank Select Decoder

This block sits in front of two memory banks, a flash bank and an SRAM bank, that share one address bus, one data bus, one write strobe and one read strobe. Three bank-enable inputs of mixed polarity pick the bank. The flash bank has one active-low enable. The SRAM has two enables, one active-low and one active-high, and both must be asserted for it to be selected. From these inputs the block decodes which bank is active and whether the pair is in standby.

The block also controls the shared tri-state data output. The bus is driven only for a legal read of exactly one bank, and it then carries that bank's read data. When both banks are selected at the same time the bus would see contention. The block suppresses any drive at once and raises a sticky fault flag on the next clock edge. Only a synchronous reset clears that flag. The storage arrays themselves are not part of the block.

Top module: `combo_bank_decoder`

## Requirements
- R1: `flash_act` is 1 exactly when `flash_en_n` is 0, whatever the other inputs are.
- R2: `sram_act` is 1 exactly when `sram_en_n` is 0 and `sram_en_hi` is 1 in the same cycle.
- R3: `standby` is 1 when `flash_en_n` and `sram_en_n` are both 1, or when `flash_en_n` is 1 and `sram_en_hi` is 0. Otherwise it is 0.
- R4: A flash read sets `dq_oe` to 1 and places `flash_rdata` on `dq_out`. A flash read means the flash bank is selected, `oe_n` is 0, there is no contention and the fault flag is clear. The write strobe `we_n` has no effect on this.
- R5: An SRAM read sets `dq_oe` to 1 and places `sram_rdata` on `dq_out`. An SRAM read means the SRAM is selected, `oe_n` is 0, `we_n` is 1, there is no contention and the fault flag is clear.
- R6: When neither R4 nor R5 applies, `dq_oe` is 0 and `dq_out` is all zeros. At most one bank drives at any time.
- R7: A cycle in which both the flash bank and the SRAM are selected sets `fault` to 1 at the next rising clock edge. After that, `fault` stays 1 whatever the inputs do.
- R8: `fault` is 0 after a cycle with `rst` high at a rising clock edge. Reset is the only way to clear it.
- R9: `dq_oe` is 0 in any cycle where both banks are selected. It is also 0 in every cycle while `fault` is 1, even for otherwise legal reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the fault flag |
| rst | input | 1 | Synchronous reset, active high |
| flash_en_n | input | 1 | Flash bank enable, active low |
| sram_en_n | input | 1 | SRAM enable, active low |
| sram_en_hi | input | 1 | SRAM enable, active high |
| we_n | input | 1 | Shared write strobe, active low |
| oe_n | input | 1 | Shared read strobe, active low |
| flash_rdata | input | DATA_W | Read data from the flash bank |
| sram_rdata | input | DATA_W | Read data from the SRAM bank |
| flash_act | output | 1 | Flash bank selected |
| sram_act | output | 1 | SRAM bank selected |
| standby | output | 1 | Neither bank selected |
| fault | output | 1 | Sticky contention flag |
| dq_oe | output | 1 | Shared data bus output enable |
| dq_out | output | DATA_W | Data for the shared bus |

## Verification
A read request and a bank contention can arrive in the same cycle. In that case the read-gating function and the fault detector both react to the same input pattern, but on different timing. The bench applies both enables together with `oe_n` low. It then requires `dq_oe` to be 0 in that same cycle, before any clock edge, and `fault` to still be 0. One edge later it requires `fault` to be 1. It then returns to a legal flash read and requires the bus to stay undriven until a reset is applied.

// File: rtl/cbd_pkg.sv
package cbd_pkg;

  // Drive source on the shared data bus
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_FLASH = 2'd1,
    SRC_SRAM  = 2'd2
  } drv_src_e;

  function automatic logic flash_sel_f(input logic en_n);
    return !en_n;
  endfunction

  function automatic logic sram_sel_f(input logic en_n, input logic en_hi);
    return !en_n && en_hi;
  endfunction

  function automatic logic idle_f(input logic f_en_n, input logic s_en_n,
                                  input logic s_en_hi);
    return (f_en_n && s_en_n) || (f_en_n && !s_en_hi);
  endfunction

endpackage

// File: rtl/cbd_bank_sel.sv
module cbd_bank_sel
  import cbd_pkg::*;
(
  input  logic flash_en_n,
  input  logic sram_en_n,
  input  logic sram_en_hi,
  output logic flash_sel,
  output logic sram_sel,
  output logic idle,
  output logic clash
);
  always_comb begin
    flash_sel = flash_sel_f(flash_en_n);
    sram_sel  = sram_sel_f(sram_en_n, sram_en_hi);
    idle      = idle_f(flash_en_n, sram_en_n, sram_en_hi);
    clash     = flash_sel && sram_sel;
  end
endmodule

// File: rtl/cbd_fault_hold.sv
module cbd_fault_hold (
  input  logic clk,
  input  logic rst,
  input  logic clash,
  output logic held
);
  always_ff @(posedge clk) begin
    if (rst) held <= 1'b0;
    else     held <= held | clash;
  end
endmodule

// File: rtl/cbd_rd_gate.sv
module cbd_rd_gate
  import cbd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              flash_sel,
  input  logic              sram_sel,
  input  logic              block_rd,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] flash_rdata,
  input  logic [DATA_W-1:0] sram_rdata,
  output logic              flash_drv,
  output logic              sram_drv,
  output logic              dq_oe,
  output logic [DATA_W-1:0] dq_out
);
  drv_src_e src;

  always_comb begin
    flash_drv = flash_sel && !oe_n && !block_rd;
    sram_drv  = sram_sel && !oe_n && we_n && !block_rd;
    if (flash_drv)     src = SRC_FLASH;
    else if (sram_drv) src = SRC_SRAM;
    else               src = SRC_NONE;
    dq_oe = (src != SRC_NONE);
  end

  // AND-OR data steering, one slice per bit
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign dq_out[b] = ((src == SRC_FLASH) && flash_rdata[b]) ||
                       ((src == SRC_SRAM)  && sram_rdata[b]);
  end
endmodule

// File: rtl/combo_bank_decoder.sv
module combo_bank_decoder #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flash_en_n,
  input  logic              sram_en_n,
  input  logic              sram_en_hi,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] flash_rdata,
  input  logic [DATA_W-1:0] sram_rdata,
  output logic              flash_act,
  output logic              sram_act,
  output logic              standby,
  output logic              fault,
  output logic              dq_oe,
  output logic [DATA_W-1:0] dq_out
);
  // Named internal events for the checker
  logic flash_sel, sram_sel, idle, clash, held, block_rd;
  logic flash_drv, sram_drv;

  cbd_bank_sel u_sel (
    .flash_en_n(flash_en_n), .sram_en_n(sram_en_n), .sram_en_hi(sram_en_hi),
    .flash_sel(flash_sel), .sram_sel(sram_sel), .idle(idle), .clash(clash)
  );

  cbd_fault_hold u_hold (
    .clk(clk), .rst(rst), .clash(clash), .held(held)
  );

  // Block reads in the clash cycle itself and for as long as the flag holds
  assign block_rd = clash || held;

  cbd_rd_gate #(.DATA_W(DATA_W)) u_gate (
    .flash_sel(flash_sel), .sram_sel(sram_sel), .block_rd(block_rd),
    .we_n(we_n), .oe_n(oe_n),
    .flash_rdata(flash_rdata), .sram_rdata(sram_rdata),
    .flash_drv(flash_drv), .sram_drv(sram_drv),
    .dq_oe(dq_oe), .dq_out(dq_out)
  );

  assign flash_act = flash_sel;
  assign sram_act  = sram_sel;
  assign standby   = idle;
  assign fault     = held;
endmodule

// File: rtl/cbd_chk.sv
module cbd_chk (
  input logic clk,
  input logic rst,
  input logic flash_act,
  input logic sram_act,
  input logic standby,
  input logic fault,
  input logic dq_oe,
  input logic oe_n,
  input logic we_n,
  input logic flash_drv,
  input logic sram_drv
);
  // R7
  fault_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (flash_act && sram_act) |=> fault);

  // R7
  fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    fault |=> fault);

  // R8
  fault_reset_chk: assert property (@(posedge clk)
    $past(rst) |-> !fault);

  // R9
  no_drive_clash_chk: assert property (@(posedge clk) disable iff (rst)
    (fault || (flash_act && sram_act)) |-> !dq_oe);

  // R6
  single_driver_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({flash_drv, sram_drv}));

  // R3
  standby_excl_chk: assert property (@(posedge clk) disable iff (rst)
    standby |-> !(flash_act || sram_act));

  // R5
  sram_write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!we_n && !flash_act) |-> !dq_oe);

  // R6
  read_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !dq_oe);
endmodule

bind combo_bank_decoder cbd_chk u_chk (
  .clk(clk), .rst(rst), .flash_act(flash_act), .sram_act(sram_act),
  .standby(standby), .fault(fault), .dq_oe(dq_oe), .oe_n(oe_n), .we_n(we_n),
  .flash_drv(flash_drv), .sram_drv(sram_drv)
);

// File: tb/tb_combo_bank_decoder.sv
module tb_combo_bank_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 16;
  localparam logic [DATA_W-1:0] FDATA = 16'hA5C3;
  localparam logic [DATA_W-1:0] SDATA = 16'h3C5A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flash_en_n = 1'b1, sram_en_n = 1'b1, sram_en_hi = 1'b0;
  logic we_n = 1'b1, oe_n = 1'b1;
  logic flash_act, sram_act, standby, fault, dq_oe;
  logic [DATA_W-1:0] dq_out;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  combo_bank_decoder #(.DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst), .flash_en_n(flash_en_n), .sram_en_n(sram_en_n),
    .sram_en_hi(sram_en_hi), .we_n(we_n), .oe_n(oe_n),
    .flash_rdata(FDATA), .sram_rdata(SDATA),
    .flash_act(flash_act), .sram_act(sram_act), .standby(standby),
    .fault(fault), .dq_oe(dq_oe), .dq_out(dq_out)
  );

  // Vector: {fe_n, se_n, se_hi, we_n, oe_n, exp_flash, exp_sram, exp_stby, exp_src[1:0]}
  // exp_src: 0 none, 1 flash data, 2 sram data
  localparam logic [9:0] VEC [0:9] = '{
    {5'b11010, 3'b001, 2'd0},
    {5'b11110, 3'b001, 2'd0},
    {5'b10010, 3'b001, 2'd0},
    {5'b01010, 3'b100, 2'd1},
    {5'b01111, 3'b100, 2'd0},
    {5'b01000, 3'b100, 2'd1},
    {5'b10110, 3'b010, 2'd2},
    {5'b10100, 3'b010, 2'd0},
    {5'b10111, 3'b010, 2'd0},
    {5'b00010, 3'b100, 2'd1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [4:0] v);
    @(negedge clk);
    {flash_en_n, sram_en_n, sram_en_hi, we_n, oe_n} = v;
    #1;
  endtask

  task automatic check_bus(input string req, input logic [1:0] src);
    logic [DATA_W-1:0] exp_d;
    exp_d = (src == 2'd1) ? FDATA : (src == 2'd2) ? SDATA : '0;
    check(req, {31'd0, dq_oe}, {31'd0, src != 2'd0});
    check(req, {16'd0, dq_out}, {16'd0, exp_d});
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 5000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R8: reset state
    check("R8 fault after reset", {31'd0, fault}, 32'd0);
    rst = 1'b0;

    // R1 R2 R3 R4 R5 R6: table walk
    foreach (VEC[i]) begin
      apply(VEC[i][9:5]);
      check("R1 flash_act", {31'd0, flash_act}, {31'd0, VEC[i][4]});
      check("R2 sram_act", {31'd0, sram_act}, {31'd0, VEC[i][3]});
      check("R3 standby", {31'd0, standby}, {31'd0, VEC[i][2]});
      check_bus("R4/R5/R6 bus", VEC[i][1:0]);
    end
    check("R7 no fault from legal traffic", {31'd0, fault}, 32'd0);

    // R9: contention with a read in the same cycle
    apply(5'b00110);
    check("R9 no drive in clash cycle", {31'd0, dq_oe}, 32'd0);
    check("R6 bus zero in clash cycle", {16'd0, dq_out}, 32'd0);
    check("R7 fault not yet set", {31'd0, fault}, 32'd0);
    @(posedge clk); #1;
    check("R7 fault set after edge", {31'd0, fault}, 32'd1);

    // R7 sticky, R9 reads blocked while flag holds
    apply(5'b01010);
    check("R9 flash read blocked by fault", {31'd0, dq_oe}, 32'd0);
    apply(5'b10110);
    check("R9 sram read blocked by fault", {31'd0, dq_oe}, 32'd0);
    apply(5'b11011);
    repeat (3) @(posedge clk);
    #1;
    check("R7 fault sticky", {31'd0, fault}, 32'd1);

    // R8: only reset clears
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R8 fault cleared by reset", {31'd0, fault}, 32'd0);
    apply(5'b01010);
    check_bus("R4 flash read after reset", 2'd1);
    apply(5'b10110);
    check_bus("R5 sram read after reset", 2'd2);

    // R9: clash without a read still sets the flag and blocks later reads
    apply(5'b00111);
    @(posedge clk); #1;
    check("R7 fault from idle clash", {31'd0, fault}, 32'd1);
    apply(5'b10110);
    check("R9 sram read blocked", {31'd0, dq_oe}, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule